// File: doc/BRIEF.md
# Selection Timeout Timer

This block times out a bus selection or reselection attempt in a SCSI controller. The timeout is measured in units whose length follows the input clock frequency. Software programs two write-only settings: a 3-bit clock conversion code and an 8-bit count of timeout units. Converting a wall-clock target such as 250 ms into a unit count, rounded up, is left to software.

A start strobe launches a measurement. A prescaler divides the input clock into timeout units of `BASE_CYCLES` times the conversion factor. A unit counter then compares the elapsed units against the programmed count. If the count is reached first, the block raises a one-cycle expiry pulse. If the target answers first, the response strobe ends the measurement quietly. A busy flag shows when a measurement is running.

Top module: `seltmo_timer`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a measurement, `busy_o` and `expire_o` are 0, the conversion code is 0 and the unit count is 0.
- R2: A write with `cfg_we`=1 and `cfg_sel`=0 loads the conversion code from `cfg_wdata[2:0]`; the upper data bits are ignored. A write with `cfg_sel`=1 loads the unit count from `cfg_wdata[7:0]`.
- R3: Conversion codes 2 to 7 give a factor equal to the code. Codes 0 and 1 both give a factor of 8; code 1 is reserved.
- R4: One timeout unit lasts `BASE_CYCLES` × factor clock cycles. Let the clock edge that samples `start_i` be edge 0. Without a response or a restart, `expire_o` is 1 exactly after edge unit_length × count.
- R5: A programmed unit count of 0 behaves as 256 units.
- R6: `expire_o` is high for exactly one cycle, and `busy_o` is 0 in that same cycle.
- R7: `resp_i` sampled while busy ends the measurement with no expiry pulse. This holds even when the response falls in the cycle in which expiry would have been registered. `resp_i` while idle has no effect.
- R8: `start_i` while busy restarts the prescaler and the unit counter from zero. When `start_i` and `resp_i` come in the same cycle, the start wins.
- R9: The code and the count are captured at start. A write during a measurement, or in the same cycle as the start, affects only the next measurement.
- R10: `busy_o` is 1 in the cycle after `start_i` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 1 | 0 selects the conversion code, 1 selects the unit count |
| cfg_wdata | input | CNT_W | Write data |
| start_i | input | 1 | Selection start strobe |
| resp_i | input | 1 | Target response strobe |
| expire_o | output | 1 | One-cycle timeout pulse |
| busy_o | output | 1 | Measurement in progress |

## Verification
The hardest case to reach is a response that arrives in the very cycle the final unit completes. In that cycle the expiry and the stop compete. The bench counts edges from the start strobe to find that exact cycle and raises `resp_i` there. The full-length runs with a count of 0 and factor 8 would be far too long with the default base. The bench therefore shrinks `BASE_CYCLES` to 3, which makes a complete sweep of all codes against several counts affordable, and it compares each expiry cycle with the product computed arithmetically.

// File: rtl/seltmo_pkg.sv
package seltmo_pkg;
  localparam int CODE_W = 3;

  // Conversion factor for a clock code; 0 and reserved 1 both mean 8.
  function automatic logic [3:0] conv_factor(input logic [CODE_W-1:0] code);
    if (code < 3'd2) conv_factor = 4'd8;
    else             conv_factor = {1'b0, code};
  endfunction
endpackage

// File: rtl/seltmo_regs.sv
module seltmo_regs
  import seltmo_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CODE_W-1:0] code_q,
  output logic [CNT_W-1:0]  count_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      count_q <= '0;
    end else if (we) begin
      if (sel) count_q <= wdata;
      else     code_q  <= wdata[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/seltmo_prescale.sv
module seltmo_prescale
  import seltmo_pkg::*;
#(
  parameter int BASE_CYCLES = 7682
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int LEN_W = $clog2(BASE_CYCLES * 8 + 1);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] pre_q;
  logic [LEN_W-1:0] len_d;
  logic             last;

  assign len_d = LEN_W'(BASE_CYCLES * int'(conv_factor(code)));
  assign last  = (pre_q == len_q - 1'b1);
  assign tick  = run && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      pre_q <= '0;
    end else if (load) begin
      len_q <= len_d;
      pre_q <= '0;
    end else if (run) begin
      pre_q <= last ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/seltmo_units.sv
module seltmo_units #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             resp,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  output logic             busy_o,
  output logic             expire_o
);
  localparam int U_W = CNT_W + 1;

  logic [U_W-1:0] limit_q;
  logic [U_W-1:0] units_q;
  logic [U_W-1:0] units_nx;

  assign units_nx = units_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o   <= 1'b0;
      expire_o <= 1'b0;
      units_q  <= '0;
      limit_q  <= '0;
    end else begin
      expire_o <= 1'b0;
      if (start) begin
        busy_o  <= 1'b1;
        units_q <= '0;
        limit_q <= (count == '0) ? (U_W'(1) << CNT_W) : {1'b0, count};
      end else if (busy_o && resp) begin
        busy_o <= 1'b0;
      end else if (busy_o && tick) begin
        if (units_nx == limit_q) begin
          busy_o   <= 1'b0;
          expire_o <= 1'b1;
          units_q  <= '0;
        end else begin
          units_q <= units_nx;
        end
      end
    end
  end
endmodule

// File: rtl/seltmo_timer.sv
module seltmo_timer
  import seltmo_pkg::*;
#(
  parameter int BASE_CYCLES = 7682,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             start_i,
  input  logic             resp_i,
  output logic             expire_o,
  output logic             busy_o
);
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  count_q;
  logic              tick;

  seltmo_regs #(.CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .code_q(code_q), .count_q(count_q)
  );

  seltmo_prescale #(.BASE_CYCLES(BASE_CYCLES)) i_pre (
    .clk(clk), .rst(rst), .load(start_i), .run(busy_o),
    .code(code_q), .tick(tick)
  );

  seltmo_units #(.CNT_W(CNT_W)) i_units (
    .clk(clk), .rst(rst), .start(start_i), .resp(resp_i), .tick(tick),
    .count(count_q), .busy_o(busy_o), .expire_o(expire_o)
  );
endmodule

// File: rtl/seltmo_checker.sv
module seltmo_checker (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic resp_i,
  input logic busy_o,
  input logic expire_o
);
  AST_EXPIRE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
    expire_o |-> !busy_o); // R6
  AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o); // R6
  AST_EXPIRE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(expire_o) |-> $past(busy_o)); // R4
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (busy_o && !expire_o)); // R10
  AST_RESP_STOPS: assert property (@(posedge clk) disable iff (rst)
    (resp_i && !start_i) |=> (!busy_o && !expire_o)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> (!busy_o && !expire_o)); // R7
endmodule

bind seltmo_timer seltmo_checker i_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .resp_i(resp_i),
  .busy_o(busy_o), .expire_o(expire_o)
);

// File: tb/test_seltmo_timer.sv
module test_seltmo_timer;
  localparam int BASE = 3;
  localparam int CW   = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          start_i = 1'b0;
  logic          resp_i = 1'b0;
  logic          expire_o;
  logic          busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  seltmo_timer #(.BASE_CYCLES(BASE), .CNT_W(CW)) i_seltmo_timer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start_i(start_i), .resp_i(resp_i),
    .expire_o(expire_o), .busy_o(busy_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int factor(input int code);
    return (code < 2) ? 8 : code;
  endfunction

  task automatic wr(input bit sel, input int data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = CW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Counts edges after the start edge until expiry; 0 if none within maxc.
  task automatic wait_expire(input int maxc, output int n);
    n = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (expire_o) begin n = i; return; end
    end
  endtask

  task automatic no_expire(input int cyc, input string req);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (expire_o) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n, exp_n;
    int cnts[5] = '{1, 2, 5, 255, 0};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
    chk(expire_o == 1'b0, "R1 expire after reset", int'(expire_o), 0);

    // R3 R4 R5 R6 R10: sweep every code against several counts
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 5; k++) begin
        wr(1'b0, c);
        wr(1'b1, cnts[k]);
        pulse_start();
        chk(busy_o == 1'b1, "R10 busy after start", int'(busy_o), 1);
        exp_n = BASE * factor(c) * ((cnts[k] == 0) ? 256 : cnts[k]);
        wait_expire(exp_n + 20, n);
        chk(n == exp_n, "R3 R4 R5 expiry cycle", n, exp_n);
        chk(busy_o == 1'b0, "R6 busy low at expiry", int'(busy_o), 0);
        @(negedge clk);
        chk(expire_o == 1'b0, "R6 pulse one cycle", int'(expire_o), 0);
      end
    end

    // R2 upper bits of code write ignored: 0xF3 -> code 3
    wr(1'b0, 8'hF3); wr(1'b1, 1);
    pulse_start();
    wait_expire(100, n);
    chk(n == BASE * 3, "R2 code field bits", n, BASE * 3);

    // R7 response mid-run
    wr(1'b0, 2); wr(1'b1, 4);
    pulse_start();
    repeat (10) @(negedge clk);
    resp_i = 1'b1; @(negedge clk); resp_i = 1'b0;
    chk(busy_o == 1'b0, "R7 resp stops", int'(busy_o), 0);
    no_expire(40, "R7 no expiry after resp");

    // R7 response in the final cycle
    wr(1'b1, 1);
    pulse_start();
    repeat (BASE * 2 - 1) @(negedge clk);
    resp_i = 1'b1; @(negedge clk); resp_i = 1'b0;
    chk(expire_o == 1'b0, "R7 final-cycle resp", int'(expire_o), 0);
    chk(busy_o == 1'b0, "R7 final-cycle busy", int'(busy_o), 0);
    no_expire(12, "R7 final-cycle later");

    // R7 resp while idle
    resp_i = 1'b1; @(negedge clk); resp_i = 1'b0;
    chk(busy_o == 1'b0, "R7 idle resp", int'(busy_o), 0);

    // R8 restart while busy
    wr(1'b1, 2);
    pulse_start();
    repeat (7) @(negedge clk);
    pulse_start();
    wait_expire(100, n);
    chk(n == BASE * 2 * 2, "R8 restart from zero", n, BASE * 4);

    // R8 start and resp together
    start_i = 1'b1; resp_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; resp_i = 1'b0;
    chk(busy_o == 1'b1, "R8 start wins", int'(busy_o), 1);
    wait_expire(100, n);
    chk(n == BASE * 4, "R8 start wins expiry", n, BASE * 4);

    // R9 writes during a run apply to the next run
    pulse_start();
    wr(1'b1, 9);
    wr(1'b0, 7);
    wait_expire(100, n);
    chk(n + 2 == BASE * 4, "R9 snapshot during run", n + 2, BASE * 4);
    pulse_start();
    wait_expire(400, n);
    chk(n == BASE * 7 * 9, "R9 next run new values", n, BASE * 63);

    // R9 write in the same cycle as start
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'd1; start_i = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; start_i = 1'b0;
    wait_expire(400, n);
    chk(n == BASE * 63, "R9 same-cycle write", n, BASE * 63);
    pulse_start();
    wait_expire(100, n);
    chk(n == BASE * 7, "R9 same-cycle write later", n, BASE * 7);

    // R1 reset mid-run returns defaults (factor 8, 256 units)
    pulse_start();
    repeat (5) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(busy_o == 1'b0, "R1 busy after mid-run reset", int'(busy_o), 0);
    no_expire(30, "R1 no expiry after reset");
    pulse_start();
    wait_expire(BASE * 8 * 256 + 20, n);
    chk(n == BASE * 8 * 256, "R1 default settings", n, BASE * 2048);

    summary();
  end
endmodule